// File: doc/BRIEF.md
# In-Place Execution Window Partition

This block is one slice of an out-of-order core's instruction window in which instructions execute where they sit, rather than being sent out to shared execution lanes. The slice holds four ordered entries. Four 16-bit register columns run through it from top to bottom. Each entry takes its two operands from the columns entering it and puts its ALU result onto its destination column. Every other column passes through the entry unchanged. The column values ripple combinationally through the entries, so the nearest earlier writer of a register supplies that register's value. This resolves dependences by position alone, and no rename table is needed.

Timing is set by a ready flag per register column. The flag is registered at every entry, so readiness moves down by one entry per clock. An entry raises the flag on its destination column only once the flags on both of its source columns are set. After all four entries have loaded, the partition executes. When the flags leaving the last entry are all set, it copies the bottom column values into its architectural register latches and holds the retired state. A one-cycle acknowledge then reopens it for the next group.

A mispredicted branch can cancel all entries younger than a given entry. A cancelled entry then behaves as a pass-through.

Top module: `inplace_window`

## Requirements
- R1: After reset, `loadReady` is 1 and `retired` is 0. Architectural register r (r = 0..3) holds (r+1)*16'h1357, truncated to 16 bits. Register r sits at `archOut[16*r +: 16]`.
- R2: While `loadReady` is 1, each cycle with `wrValid` high writes the next entry, starting at entry 0 (the oldest). The fourth write ends loading. `wrValid` has no effect while `loadReady` is 0.
- R3: The opcode `wrOp` selects the operation: 0 add (A+B), 1 subtract (A-B, modulo 2^16), 2 bitwise and, 3 bitwise or. A comes from the column named by `wrSrcA` and B from the column named by `wrSrcB`. The result replaces only the `wrDst` column.
- R4: An entry's operand is the value written by the nearest earlier non-cancelled entry with that destination. If no such entry exists, the operand is the architectural value. The retired state equals sequential execution of the group in program order.
- R5: Without a flush in the final execute cycle, `retired` rises exactly 5 clock edges after the edge that accepts the fourth write. This is one edge per entry for ready-flag propagation, plus one commit edge.
- R6: `archOut` changes only on the edge where `retired` rises.
- R7: `flushReq` during execution cancels every entry whose index is greater than `flushAfter`. With `flushAfter` = 3, it has no effect. It is ignored while loading or retired.
- R8: A flush in the cycle in which all ready flags have arrived postpones the commit by one cycle. The commit then uses the flushed group.
- R9: `retired` stays high until `retireDone` is seen high on an edge. On the next cycle `loadReady` is 1. `retireDone` is ignored at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Front-end writes one instruction this cycle |
| wrOp | input | 2 | Operation code of the written instruction |
| wrDst | input | 2 | Destination register |
| wrSrcA | input | 2 | First source register |
| wrSrcB | input | 2 | Second source register |
| flushReq | input | 1 | Branch mispredict: cancel younger entries |
| flushAfter | input | 2 | Index of the youngest entry that survives the flush |
| retireDone | input | 1 | Acknowledge of retirement; reopens loading |
| loadReady | output | 1 | Partition is accepting instructions |
| retired | output | 1 | Group has committed into the architectural latches |
| archOut | output | 64 | Architectural register latches, register r at [16r+15:16r] |

## Verification
The hardest situation to reach is a flush that lands in the same cycle as the last ready flags. In that cycle the commit must be held off and the cancelled entries must drop out of the result. The bench reaches it by counting execute cycles from the fourth write and raising `flushReq` in the fifth. Other runs move the flush to earlier cycles and to the no-op index 3. Some runs also drive junk writes, flushes and acknowledges while the partition is executing or retired, to show that they are ignored. The reference model replays each group sequentially at commit and compares its result every cycle.

// File: rtl/window_pkg.sv
package window_pkg;
  localparam int REG_COUNT = 4;
  localparam int REG_W     = $clog2(REG_COUNT);
  localparam int ENTRIES   = 4;
  localparam int IDX_W     = $clog2(ENTRIES);

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } aluOp_e;

  typedef struct packed {
    aluOp_e           op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
  } instr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] loadIdx;
    logic             clearComp;
    logic             advance;
    logic             flush;
    logic             commit;
  } strobe_t;
endpackage

// File: rtl/window_ctrl.sv
module window_ctrl
  import window_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrValid,
  input  logic    flushReq,
  input  logic    retireDone,
  input  logic    allDone,
  output strobe_t strobe,
  output logic    loadReady,
  output logic    retired
);
  typedef enum logic [1:0] {ST_LOAD, ST_EXEC, ST_HOLD} state_e;

  state_e           state;
  logic [IDX_W-1:0] count;

  always_comb begin
    strobe         = '0;
    strobe.loadIdx = count;
    case (state)
      ST_LOAD: begin
        strobe.load      = wrValid;
        strobe.clearComp = 1'b1;
      end
      ST_EXEC: begin
        strobe.advance = 1'b1;
        strobe.flush   = flushReq;
        strobe.commit  = allDone && !flushReq;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOAD;
      count <= '0;
    end else begin
      case (state)
        ST_LOAD: if (wrValid) begin
          count <= count + 1'b1;
          if (count == IDX_W'(ENTRIES - 1)) state <= ST_EXEC;
        end
        ST_EXEC: if (strobe.commit) state <= ST_HOLD;
        default: if (retireDone) begin
          state <= ST_LOAD;
          count <= '0;
        end
      endcase
    end
  end

  assign loadReady = (state == ST_LOAD);
  assign retired   = (state == ST_HOLD);
endmodule

// File: rtl/window_entry.sv
module window_entry
  import window_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  instr_t                             instr,
  input  logic                               killed,
  input  logic [REG_COUNT-1:0][DATA_W-1:0]   colIn,
  input  logic [REG_COUNT-1:0]               compIn,
  input  logic                               clearComp,
  input  logic                               advance,
  output logic [REG_COUNT-1:0][DATA_W-1:0]   colOut,
  output logic [REG_COUNT-1:0]               compOut
);
  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] result;
  logic              srcReady;

  always_comb begin
    opA = colIn[instr.srcA];
    opB = colIn[instr.srcB];
    case (instr.op)
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_AND:  result = opA & opB;
      default: result = opA | opB;
    endcase
    for (int r = 0; r < REG_COUNT; r++)
      colOut[r] = (!killed && instr.dst == REG_W'(r)) ? result : colIn[r];
  end

  assign srcReady = compIn[instr.srcA] & compIn[instr.srcB];

  // ready flags are the only clocked state on the column path
  always_ff @(posedge clk) begin
    if (!rstN || clearComp) begin
      compOut <= '0;
    end else if (advance) begin
      for (int r = 0; r < REG_COUNT; r++)
        compOut[r] <= (!killed && instr.dst == REG_W'(r)) ? srcReady : compIn[r];
    end
  end
endmodule

// File: rtl/window_datapath.sv
module window_datapath
  import window_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter logic [15:0] RESET_STEP = 16'h1357
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strobe,
  input  instr_t                        wrInstr,
  input  logic [IDX_W-1:0]              flushAfter,
  output logic                          allDone,
  output logic [REG_COUNT*DATA_W-1:0]   archOut
);
  instr_t                            slot [ENTRIES];
  logic [ENTRIES-1:0]                killed;
  logic [REG_COUNT-1:0][DATA_W-1:0]  archReg;
  logic [REG_COUNT-1:0][DATA_W-1:0]  col  [ENTRIES+1];
  logic [REG_COUNT-1:0]              comp [ENTRIES+1];

  assign col[0]  = archReg;
  assign comp[0] = '1;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
    window_entry #(.DATA_W(DATA_W)) u_entry (
      .clk      (clk),
      .rstN     (rstN),
      .instr    (slot[k]),
      .killed   (killed[k]),
      .colIn    (col[k]),
      .compIn   (comp[k]),
      .clearComp(strobe.clearComp),
      .advance  (strobe.advance),
      .colOut   (col[k+1]),
      .compOut  (comp[k+1])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot[k]   <= '0;
        killed[k] <= 1'b0;
      end else if (strobe.load && strobe.loadIdx == IDX_W'(k)) begin
        slot[k]   <= wrInstr;
        killed[k] <= 1'b0;
      end else if (strobe.flush && IDX_W'(k) > flushAfter) begin
        killed[k] <= 1'b1;
      end
    end
  end

  assign allDone = &comp[ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < REG_COUNT; r++)
        archReg[r] <= DATA_W'((r + 1) * RESET_STEP);
    end else if (strobe.commit) begin
      archReg <= col[ENTRIES];
    end
  end

  assign archOut = archReg;
endmodule

// File: rtl/inplace_window.sv
module inplace_window
  import window_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrValid,
  input  logic [1:0]                  wrOp,
  input  logic [REG_W-1:0]            wrDst,
  input  logic [REG_W-1:0]            wrSrcA,
  input  logic [REG_W-1:0]            wrSrcB,
  input  logic                        flushReq,
  input  logic [IDX_W-1:0]            flushAfter,
  input  logic                        retireDone,
  output logic                        loadReady,
  output logic                        retired,
  output logic [REG_COUNT*DATA_W-1:0] archOut
);
  strobe_t strobe;
  instr_t  wrInstr;
  logic    allDone;

  assign wrInstr = '{op: aluOp_e'(wrOp), dst: wrDst, srcA: wrSrcA, srcB: wrSrcB};

  window_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .flushReq  (flushReq),
    .retireDone(retireDone),
    .allDone   (allDone),
    .strobe    (strobe),
    .loadReady (loadReady),
    .retired   (retired)
  );

  window_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrInstr   (wrInstr),
    .flushAfter(flushAfter),
    .allDone   (allDone),
    .archOut   (archOut)
  );
endmodule

// File: rtl/window_checker.sv
module window_checker
  import window_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        loadReady,
  input logic                        retired,
  input logic                        retireDone,
  input logic [REG_COUNT*DATA_W-1:0] archOut
);
  logic [7:0] execCycles;

  always_ff @(posedge clk) begin
    if (!rstN || loadReady) execCycles <= '0;
    else if (!retired && execCycles != 8'hFF) execCycles <= execCycles + 8'd1;
  end

  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(loadReady && retired)); // R2

  AST_LOAD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    loadReady |=> !retired); // R2

  AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retired) |-> execCycles >= 8'(ENTRIES + 1)); // R5

  AST_ARCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(retired) |-> $stable(archOut)); // R6

  AST_HOLD_STAY: assert property (@(posedge clk) disable iff (!rstN)
    retired && !retireDone |=> retired); // R9

  AST_REOPEN: assert property (@(posedge clk) disable iff (!rstN)
    retired && retireDone |=> loadReady); // R9
endmodule

bind inplace_window window_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadReady (loadReady),
  .retired   (retired),
  .retireDone(retireDone),
  .archOut   (archOut)
);

// File: tb/test_inplace_window.sv
`timescale 1ns/1ps
module test_inplace_window;
  import window_pkg::*;
  localparam int DW = 16;
  localparam int N  = ENTRIES;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, wrValid = 1'b0, flushReq = 1'b0, retireDone = 1'b0;
  logic [1:0] wrOp = '0, wrDst = '0, wrSrcA = '0, wrSrcB = '0, flushAfter = '0;
  logic loadReady, retired;
  logic [4*DW-1:0] archOut;

  inplace_window #(.DATA_W(DW)) i_inplace_window (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrOp(wrOp), .wrDst(wrDst),
    .wrSrcA(wrSrcA), .wrSrcB(wrSrcB), .flushReq(flushReq), .flushAfter(flushAfter),
    .retireDone(retireDone), .loadReady(loadReady), .retired(retired), .archOut(archOut)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 loading, 1 executing, 2 retired
  int mState, mCount, mExecCyc;
  logic [7:0] mSlot [N];
  bit mKill [N];
  logic [DW-1:0] mArch [4];

  function automatic logic [DW-1:0] aluRef(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [7:0] mk(int op, int d, int a, int b);
    return {2'(op), 2'(d), 2'(a), 2'(b)};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCount = 0; mExecCyc = 0;
      for (int r = 0; r < 4; r++) mArch[r] = DW'((r + 1) * 16'h1357);
      for (int k = 0; k < N; k++) begin mSlot[k] = '0; mKill[k] = 0; end
    end else begin
      case (mState)
        0: if (wrValid) begin
          mSlot[mCount] = {wrOp, wrDst, wrSrcA, wrSrcB};
          mKill[mCount] = 0;
          mCount++;
          if (mCount == N) begin mState = 1; mExecCyc = 0; end
        end
        1: begin
          if (flushReq)
            for (int k = 0; k < N; k++) if (k > int'(flushAfter)) mKill[k] = 1;
          if (mExecCyc >= N && !flushReq) begin
            for (int k = 0; k < N; k++) if (!mKill[k])
              mArch[mSlot[k][5:4]] = aluRef(int'(mSlot[k][7:6]),
                                           mArch[mSlot[k][3:2]], mArch[mSlot[k][1:0]]);
            mState = 2;
          end
          mExecCyc++;
        end
        default: if (retireDone) begin mState = 0; mCount = 0; end
      endcase
    end
  end

  // compare against the reference on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 loadReady", 64'(loadReady), 64'(mState == 0));
      chk("R9 retired", 64'(retired), 64'(mState == 2));
      chk("R3 R4 R6 R7 archOut", archOut, {mArch[3], mArch[2], mArch[1], mArch[0]});
    end
  end

  task automatic runBlock(input logic [7:0] prog [N], input int flushAt, input int fAfter,
                          input bit junk, input int expLat, input string tag);
    int lat = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      {wrOp, wrDst, wrSrcA, wrSrcB} = prog[i];
    end
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (retired) break;
      lat++;
      wrValid    = junk;                    // R2: ignored while executing
      {wrOp, wrDst, wrSrcA, wrSrcB} = 8'hE4;
      retireDone = junk;                    // R9: ignored while executing
      flushReq   = (c == flushAt);
      flushAfter = 2'(fAfter);
    end
    flushReq = junk;                        // R7: ignored once retired
    retireDone = 1'b0;
    chk({tag, " R5 R8 latency"}, 64'(lat), 64'(expLat));
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      chk({tag, " R9 hold"}, 64'(retired), 64'd1);
    end
    wrValid = 1'b0; flushReq = 1'b0; retireDone = 1'b1;
    @(negedge clk);
    retireDone = 1'b0;
    chk({tag, " R9 reopen"}, 64'(loadReady), 64'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    nCmp++; nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [7:0] p1 [N];
    logic [7:0] p2 [N];
    p1 = '{mk(0,2,0,0), mk(1,3,0,2), mk(0,2,2,3), mk(0,2,0,3)};
    p2 = '{mk(2,0,1,2), mk(3,1,0,3), mk(1,2,3,1), mk(0,3,3,3)};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 loadReady", 64'(loadReady), 64'd1);
    chk("R1 retired", 64'(retired), 64'd0);
    chk("R1 archOut", archOut, 64'h4D5C_3A05_26AE_1357);

    runBlock(p1, -1, 0, 0, N + 1, "chain");
    chk("R3 R4 chain result", archOut, 64'hECA9_0000_26AE_1357);
    runBlock(p2, -1, 0, 1, N + 1, "junk");
    runBlock(p2, 2, 1, 0, N + 1, "R7 midflush");
    runBlock(p1, 0, 3, 0, N + 1, "R7 noop flush");
    runBlock(p1, N, 0, 0, N + 2, "R8 late flush");
    runBlock(p2, 0, 0, 1, N + 1, "R7 early flush");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule